// File: doc/BRIEF.md
# Machine-Cycle Timer/Counter with Edge Capture

This block holds a 16-bit count, split into a low byte and a high byte, that advances once per machine cycle. A machine cycle lasts a parameterised number of clocks (12 by default). In timer mode the count steps at the end of every machine cycle. In counter mode it steps only when a falling edge has been seen on an external count pin. The pin is sampled once per machine cycle, at a fixed phase. An edge is a high sample followed by a low sample, and the step lands at the end of the machine cycle in which the low sample was taken.

A second pin, the capture pin, goes through the same sampling rule. When the external-enable bit is set, a falling edge on it copies the count into a 16-bit capture register and sets a sticky external flag. When the count wraps from FFFFh to 0000h, it sets a sticky overflow flag. Either flag drives the interrupt request output. A CPU-side write port loads the control register, the two count bytes and the two capture bytes.

Each pin has its own edge sampler, a two-state machine. State `SMP_LOW` means the last sample was low, and state `SMP_HIGH` means it was high. On a sample tick, transition *arm* (from `SMP_LOW` to `SMP_HIGH`) is taken on a high sample. On a sample tick, transition *fire* (from `SMP_HIGH` to `SMP_LOW`) is taken on a low sample and marks an edge as pending. The pending mark is consumed at the end of the machine cycle. Reset enters `SMP_LOW`.

Top module: `cap_timer16`

## Requirements
- R1: After reset, `count_o`, `capture_o`, `ctrl_o` and `irq_o` are all zero. The machine-cycle phase restarts at 0 on the first clock after reset is released.
- R2: With the run bit (control bit 0) set and the counter-select bit (control bit 1) clear, the count rises by exactly one on the last clock of each machine cycle. A carry passes from the low byte into the high byte (00FFh becomes 0100h).
- R3: With the run bit clear, the count holds its value in both modes.
- R4: An increment from FFFFh gives 0000h and sets the overflow flag (control bit 7), which raises `irq_o`.
- R5: The overflow flag and the external flag (control bit 6) stay set until a control write with that bit at 0. If a hardware set and a clearing write fall in the same clock, the set wins.
- R6: A write to a count byte (`wr_sel` 1 = low byte, 2 = high byte) replaces that byte and cancels any increment due in the same clock. The other byte keeps its value.
- R7: With run and counter-select both set, the count rises by one for each high sample followed by a low sample of `cnt_pin`. The pin is sampled at phase 9 of the 12-clock machine cycle. A pin held low causes no count.
- R8: The increment caused by a counted edge appears on the last clock of the machine cycle in which the low sample was taken, and not before.
- R9: A low level on `cnt_pin` that does not cover the sampling phase is not counted.
- R10: With the external-enable bit (control bit 2) set, a falling edge on `cap_pin`, sampled by the R7 rule, copies the count into `capture_o` and sets the external flag. The value copied is the count before any increment in the same clock. With the external-enable bit clear, edges on `cap_pin` change neither `capture_o` nor the flag.
- R11: Write selects are 0 = control, 1 = count low, 2 = count high, 3 = capture low, 4 = capture high. Control bits 3 to 5 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for the write |
| wr_data | input | 8 | Write data byte |
| cnt_pin | input | 1 | External event input for counter mode |
| cap_pin | input | 1 | External capture trigger input |
| count_o | output | 16 | Current count, high byte above low byte |
| capture_o | output | 16 | Capture register |
| ctrl_o | output | 8 | Control register with both flags |
| irq_o | output | 1 | Interrupt request, the OR of the two flags |

## Verification
On the last clock of a machine cycle the increment can meet either a CPU write to a count byte or a capture. The bench aligns itself to the machine-cycle phase, which it counts from reset. It then places a count-byte write on that exact clock and expects the written byte with no increment. In a separate pass it drops `cap_pin` so that a capture falls on an incrementing clock. There it expects the capture register to hold the pre-increment count while the count shows the incremented value. A clearing control write placed on a wrapping clock is also judged: the overflow flag must stay set.

// File: rtl/cap_timer_pkg.sv
`timescale 1ns/1ps
package cap_timer_pkg;
    typedef enum logic [0:0] {
        SMP_LOW  = 1'b0,
        SMP_HIGH = 1'b1
    } smp_state_t;

    localparam logic [2:0] SEL_CTRL   = 3'd0;
    localparam logic [2:0] SEL_CNT_LO = 3'd1;
    localparam logic [2:0] SEL_CNT_HI = 3'd2;
    localparam logic [2:0] SEL_CAP_LO = 3'd3;
    localparam logic [2:0] SEL_CAP_HI = 3'd4;

    localparam int BIT_RUN  = 0;
    localparam int BIT_CTR  = 1;
    localparam int BIT_XEN  = 2;
    localparam int BIT_XFLG = 6;
    localparam int BIT_OFLG = 7;
endpackage

// File: rtl/mc_phase.sv
`timescale 1ns/1ps
module mc_phase #(
    parameter int CYC = 12,
    parameter int SMP = 9
) (
    input  logic clk,
    input  logic rst_n,
    output logic smp_tick,
    output logic end_tick
);
    localparam int PW = (CYC > 1) ? $clog2(CYC) : 1;
    localparam logic [PW-1:0] LAST = PW'(CYC - 1);
    localparam logic [PW-1:0] SPOT = PW'(SMP);

    logic [PW-1:0] ph_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           ph_q <= '0;
        else if (ph_q == LAST) ph_q <= '0;
        else                  ph_q <= ph_q + 1'b1;
    end

    assign smp_tick = (ph_q == SPOT);
    assign end_tick = (ph_q == LAST);
endmodule

// File: rtl/fall_sampler.sv
`timescale 1ns/1ps
module fall_sampler
    import cap_timer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic smp_tick,
    input  logic end_tick,
    input  logic pin,
    output logic pend_o
);
    smp_state_t st_q, st_d;
    logic       fall;

    // next state: arm on a high sample, fire on a low sample
    always_comb begin
        st_d = st_q;
        if (smp_tick) begin
            unique case (st_q)
                SMP_LOW:  if (pin)  st_d = SMP_HIGH;
                SMP_HIGH: if (!pin) st_d = SMP_LOW;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SMP_LOW;
        else        st_q <= st_d;
    end

    // output: the fire transition marks an edge pending until cycle end
    always_comb fall = smp_tick && (st_q == SMP_HIGH) && !pin;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        pend_o <= 1'b0;
        else if (end_tick) pend_o <= 1'b0;
        else if (fall)     pend_o <= 1'b1;
    end
endmodule

// File: rtl/count_core.sv
`timescale 1ns/1ps
module count_core
    import cap_timer_pkg::*;
#(
    parameter int B = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           end_tick,
    input  logic           cnt_pend,
    input  logic           cap_pend,
    input  logic           wr_en,
    input  logic [2:0]     wr_sel,
    input  logic [B-1:0]   wr_data,
    output logic [2*B-1:0] count_o,
    output logic [2*B-1:0] cap_o,
    output logic [B-1:0]   ctrl_o
);
    localparam int W = 2 * B;

    logic [W-1:0] count_q, cap_q;
    logic [2:0]   mode_q;
    logic         oflg_q, xflg_q;
    logic         wr_ctl, wr_lo, wr_hi, wr_clo, wr_chi;
    logic         step, wrap, grab;

    assign wr_ctl = wr_en && (wr_sel == SEL_CTRL);
    assign wr_lo  = wr_en && (wr_sel == SEL_CNT_LO);
    assign wr_hi  = wr_en && (wr_sel == SEL_CNT_HI);
    assign wr_clo = wr_en && (wr_sel == SEL_CAP_LO);
    assign wr_chi = wr_en && (wr_sel == SEL_CAP_HI);

    assign step = mode_q[0] && end_tick && (mode_q[1] ? cnt_pend : 1'b1);
    assign wrap = step && !wr_lo && !wr_hi && (&count_q);
    assign grab = mode_q[2] && end_tick && cap_pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
            cap_q   <= '0;
            mode_q  <= '0;
            oflg_q  <= 1'b0;
            xflg_q  <= 1'b0;
        end else begin
            if (wr_lo) count_q[B-1:0] <= wr_data;
            if (wr_hi) count_q[W-1:B] <= wr_data;
            if (!wr_lo && !wr_hi && step) count_q <= count_q + 1'b1;

            if (wr_clo) cap_q[B-1:0] <= wr_data;
            if (wr_chi) cap_q[W-1:B] <= wr_data;
            if (!wr_clo && !wr_chi && grab) cap_q <= count_q;

            if (wr_ctl) mode_q <= {wr_data[BIT_XEN], wr_data[BIT_CTR], wr_data[BIT_RUN]};
            oflg_q <= (wr_ctl ? wr_data[BIT_OFLG] : oflg_q) | wrap;
            xflg_q <= (wr_ctl ? wr_data[BIT_XFLG] : xflg_q) | grab;
        end
    end

    always_comb begin
        ctrl_o           = '0;
        ctrl_o[BIT_RUN]  = mode_q[0];
        ctrl_o[BIT_CTR]  = mode_q[1];
        ctrl_o[BIT_XEN]  = mode_q[2];
        ctrl_o[BIT_XFLG] = xflg_q;
        ctrl_o[BIT_OFLG] = oflg_q;
    end

    assign count_o = count_q;
    assign cap_o   = cap_q;
endmodule

// File: rtl/cap_timer16.sv
`timescale 1ns/1ps
module cap_timer16
    import cap_timer_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int MC_LEN    = 12,
    parameter int SMP_PHASE = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [2:0]          wr_sel,
    input  logic [BYTE_W-1:0]   wr_data,
    input  logic                cnt_pin,
    input  logic                cap_pin,
    output logic [2*BYTE_W-1:0] count_o,
    output logic [2*BYTE_W-1:0] capture_o,
    output logic [BYTE_W-1:0]   ctrl_o,
    output logic                irq_o
);
    localparam int NPIN = 2;

    logic            smp_tick, end_tick;
    logic [NPIN-1:0] pins, pend;

    assign pins = {cap_pin, cnt_pin};

    mc_phase #(.CYC(MC_LEN), .SMP(SMP_PHASE)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_tick (smp_tick),
        .end_tick (end_tick)
    );

    for (genvar g = 0; g < NPIN; g++) begin : g_smp
        fall_sampler u_smp (
            .clk      (clk),
            .rst_n    (rst_n),
            .smp_tick (smp_tick),
            .end_tick (end_tick),
            .pin      (pins[g]),
            .pend_o   (pend[g])
        );
    end

    count_core #(.B(BYTE_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .end_tick (end_tick),
        .cnt_pend (pend[0]),
        .cap_pend (pend[1]),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .count_o  (count_o),
        .cap_o    (capture_o),
        .ctrl_o   (ctrl_o)
    );

    assign irq_o = ctrl_o[BIT_OFLG] | ctrl_o[BIT_XFLG];
endmodule

// File: rtl/cap_timer16_chk.sv
`timescale 1ns/1ps
module cap_timer16_chk
    import cap_timer_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [2:0]  wr_sel,
    input logic [7:0]  wr_data,
    input logic [15:0] count_o,
    input logic [7:0]  ctrl_o
);
    logic cnt_wr, ctl_wr;
    assign cnt_wr = wr_en && ((wr_sel == SEL_CNT_LO) || (wr_sel == SEL_CNT_HI));
    assign ctl_wr = wr_en && (wr_sel == SEL_CTRL);

    assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_wr |=> (count_o == $past(count_o) || count_o == $past(count_o) + 16'd1));

    assert_hold_when_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_o[BIT_RUN] && !cnt_wr) |=> $stable(count_o));

    assert_wrap_sets_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o == 16'hFFFF && !cnt_wr) ##1 (count_o == 16'h0000) |-> ctrl_o[BIT_OFLG]);

    assert_oflag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_o[BIT_OFLG] && !ctl_wr) |=> ctrl_o[BIT_OFLG]);

    assert_xflag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_o[BIT_XFLG] && !ctl_wr) |=> ctrl_o[BIT_XFLG]);

    assert_xflag_needs_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl_o[BIT_XFLG]) |-> ($past(ctrl_o[BIT_XEN]) || $past(ctl_wr && wr_data[BIT_XFLG])));
endmodule

bind cap_timer16 cap_timer16_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .count_o (count_o),
    .ctrl_o  (ctrl_o)
);

// File: tb/cap_timer16_test.sv
`timescale 1ns/1ps
module cap_timer16_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = 3'd0;
    logic [7:0]  wr_data = 8'd0;
    logic        cnt_pin = 1'b0;
    logic        cap_pin = 1'b1;
    logic [15:0] count_o, capture_o;
    logic [7:0]  ctrl_o;
    logic        irq_o;

    int total = 0;
    int bad = 0;
    int ecnt = 0;
    bit done = 1'b0;

    typedef struct {
        int          fld;
        logic [15:0] exp;
        string       req;
    } item_t;
    item_t sbq[$];

    cap_timer16 uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .cnt_pin(cnt_pin), .cap_pin(cap_pin), .count_o(count_o), .capture_o(capture_o),
        .ctrl_o(ctrl_o), .irq_o(irq_o)
    );

    always #4 clk = ~clk;

    always @(posedge clk) if (rst_n) ecnt <= ecnt + 1;

    // monitor: compare queued expectations mid low phase
    always @(negedge clk) begin
        item_t       it;
        logic [15:0] act;
        #1;
        while (sbq.size() != 0) begin
            it = sbq.pop_front();
            case (it.fld)
                0:       act = count_o;
                1:       act = capture_o;
                2:       act = {8'h00, ctrl_o};
                default: act = {15'h0, irq_o};
            endcase
            total++;
            if (act !== it.exp) begin
                bad++;
                $display("FAIL %s field=%0d actual=%h expected=%h", it.req, it.fld, act, it.exp);
            end
        end
    end

    task automatic chk(input int fld, input logic [15:0] exp, input string req);
        item_t it;
        it.fld = fld; it.exp = exp; it.req = req;
        sbq.push_back(it);
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // leave the bench at a negedge whose next edge has phase p
    task automatic align(input int p);
        while ((ecnt % 12) != p) step(1);
    endtask

    task automatic wr(input logic [2:0] sel, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        step(1);
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk(0, 16'h0000, "R1"); chk(1, 16'h0000, "R1");
        chk(2, 16'h0000, "R1"); chk(3, 16'h0000, "R1");
        step(40);
        chk(0, 16'h0000, "R3 stopped");

        // timer mode
        align(0);
        wr(3'd0, 8'h01);
        step(59); chk(0, 16'd5, "R2 five cycles");
        step(11); chk(0, 16'd5, "R2 no early step");
        step(1);  chk(0, 16'd6, "R2 step at cycle end");

        wr(3'd1, 8'hFF);
        step(10); chk(0, 16'h00FF, "R6 low byte load");
        step(1);  chk(0, 16'h0100, "R2 carry");

        // overflow
        wr(3'd1, 8'hFF); wr(3'd2, 8'hFF);
        step(9);  chk(0, 16'hFFFF, "R4 before wrap"); chk(2, 16'h0001, "R4 flag clear");
        step(1);  chk(0, 16'h0000, "R4 wrap"); chk(2, 16'h0081, "R4 flag"); chk(3, 16'h0001, "R4 irq");
        step(12); chk(0, 16'h0001, "R5 counting on"); chk(2, 16'h0081, "R5 sticky");
        wr(3'd0, 8'h01); chk(2, 16'h0001, "R5 cleared"); chk(3, 16'h0000, "R5 irq low");

        // clearing write on a wrapping clock: set wins
        wr(3'd1, 8'hFF); wr(3'd2, 8'hFF);
        align(11);
        wr(3'd0, 8'h01);
        chk(0, 16'h0000, "R5 wrap under write"); chk(2, 16'h0081, "R5 set wins");
        wr(3'd0, 8'h01);

        // count write versus increment
        align(11);
        wr(3'd1, 8'h40); chk(0, 16'h0040, "R6 write beats step");
        step(12);        chk(0, 16'h0041, "R6 next step");
        align(11);
        wr(3'd2, 8'h12); chk(0, 16'h1241, "R6 high write beats step");

        // counter mode
        align(0);
        wr(3'd0, 8'h03); wr(3'd1, 8'h00); wr(3'd2, 8'h00);
        align(0);
        for (int k = 1; k <= 3; k++) begin
            cnt_pin = 1'b1; step(12);
            cnt_pin = 1'b0; step(10);
            step(1);  chk(0, 16'(k - 1), "R8 not yet");
            step(1);  chk(0, 16'(k), "R7 edge counted");
        end
        step(24); chk(0, 16'd3, "R7 held low");
        cnt_pin = 1'b1; step(12);
        cnt_pin = 1'b0; step(6);
        cnt_pin = 1'b1; step(6);
        step(12); chk(0, 16'd3, "R9 short low missed");
        cnt_pin = 1'b0; step(12); chk(0, 16'd4, "R7 edge after short low");

        // capture disabled, then enabled with count frozen
        align(0);
        wr(3'd0, 8'h00); wr(3'd1, 8'h34); wr(3'd2, 8'h12);
        cap_pin = 1'b0; step(24);
        chk(1, 16'h0000, "R10 ignored"); chk(2, 16'h0000, "R10 no flag");
        cap_pin = 1'b1; step(12);
        wr(3'd0, 8'h04);
        align(0);
        cap_pin = 1'b0; step(12);
        chk(1, 16'h1234, "R10 capture"); chk(2, 16'h0044, "R10 flag"); chk(3, 16'h0001, "R10 irq");
        chk(0, 16'h1234, "R3 frozen");
        cap_pin = 1'b1;

        // capture on an incrementing clock
        wr(3'd0, 8'h05); chk(2, 16'h0005, "R5 clear xflag");
        wr(3'd1, 8'h00); wr(3'd2, 8'h01);
        align(0);
        chk(0, 16'h0101, "R2 timer again");
        cap_pin = 1'b0; step(12);
        chk(1, 16'h0101, "R10 pre-increment value"); chk(0, 16'h0102, "R2 step with capture");
        chk(2, 16'h0045, "R10 flag with run");
        cap_pin = 1'b1;

        // capture byte writes
        wr(3'd3, 8'hA5); wr(3'd4, 8'h5A);
        chk(1, 16'h5AA5, "R11 capture bytes");
        wr(3'd0, 8'h38); chk(2, 16'h0000, "R11 spare bits zero");

        step(2);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule